// File: doc/BRIEF.md
# Video Fetch Address and Palette Unit

This block sits directly behind a CRT controller and makes the video-side decisions for every character clock. From the controller's 14-bit memory address and 3-bit row address it forms the two 16-bit RAM byte addresses that are read in each character period. The two reads differ only in the lowest address bit, which carries the half-character phase. Each cycle it also sorts the beam into one of three states: sync, border or pixels. It raises a one-cycle strobe whenever that state changes, so a downstream serialiser knows when to close one run of output and start the next.

A CPU register interface writes three things. The first is a pending screen mode. It becomes the active mode only when horizontal sync falls, so a mode change never splits a scan line. The second is a pen number. The third is a colour, which lands in the selected entry of a 16-pen palette, or in a separate border colour register when the pen number has its top bit set. A pen index input reads the palette combinationally. The decoding of pixel bytes and the RAM itself belong to other blocks.

Top module: `video_fetch_pal`

## Requirements
- R1: `fetchAddrA` is {memAddr[13:12], rowAddr[2:0], memAddr[9:0], 1'b0}, with bit 0 as the LSB. `fetchAddrB` is the same value with bit 0 set. memAddr[11:10] do not appear in either address. Both outputs are combinational.
- R2: If hSync or vSync is high at a clock edge, `outClass` shows sync (code 2) after that edge. Sync takes priority over dispEn.
- R3: With both syncs low at an edge, `outClass` shows pixels (code 1) after that edge if dispEn was high, and border (code 0) if dispEn was low.
- R4: `classChg` is high for exactly the one cycle in which `outClass` holds a value different from the value it held in the cycle before.
- R5: A CPU write with cpuSel=2 stores cpuData[1:0] as the pending mode. `activeMode` keeps its value on every edge where `lineEnd` is low.
- R6: `lineEnd` is high in the cycle where hSync is low and hSync was high in the cycle before. At the edge that closes that cycle, `activeMode` takes the pending mode.
- R7: If a mode write and a `lineEnd` cycle fall together, `activeMode` takes the pending mode that was held before the write. The newly written mode stays pending until the next `lineEnd`.
- R8: A write with cpuSel=0 stores cpuData[4:0] as the pen number. A write with cpuSel=1 stores cpuData[4:0] in palette entry pen[3:0] when pen bit 4 is 0, and in `borderColour` when pen bit 4 is 1. No other entry changes.
- R9: `frameStart` is high in the cycle where vSync is high and vSync was low in the cycle before.
- R10: After reset, `activeMode` is 0, the pending mode is 0, every palette entry and `borderColour` are 0, `outClass` is border, and `classChg` is 0.
- R11: While cpuWe is low, or when cpuSel=3, the palette, the border colour, the pen number and the modes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | input | 14 | CRT controller memory address |
| rowAddr | input | 3 | CRT controller row address |
| hSync | input | 1 | Horizontal sync level |
| vSync | input | 1 | Vertical sync level |
| dispEn | input | 1 | Display enable level |
| cpuWe | input | 1 | CPU register write strobe |
| cpuSel | input | 2 | Register select: 0 pen, 1 colour, 2 mode, 3 none |
| cpuData | input | 8 | CPU write data |
| penIdx | input | 4 | Palette read index |
| fetchAddrA | output | 16 | RAM byte address, phase 0 |
| fetchAddrB | output | 16 | RAM byte address, phase 1 |
| outClass | output | 2 | 0 border, 1 pixels, 2 sync |
| classChg | output | 1 | One-cycle strobe on a class change |
| lineEnd | output | 1 | Falling edge of hSync |
| frameStart | output | 1 | Rising edge of vSync |
| activeMode | output | 2 | Mode in force for the current line |
| penColour | output | 5 | Palette entry selected by penIdx |
| borderColour | output | 5 | Border colour |

## Verification
A CPU mode write and the fall of horizontal sync can land on the same clock edge. At that edge the pending register is loaded and also copied into the active mode. The bench provokes the collision by dropping hSync in the same cycle as a mode write. It then expects `activeMode` to take the mode written earlier, and the new mode to take effect only after a later fall of hSync. A class change that arrives together with a sync edge is covered as well: the bench walks every combination of hSync, vSync and dispEn and checks the class and the strobe after each edge.

// File: rtl/vfp_pkg.sv
package vfp_pkg;
  localparam int CPU_W = 8;

  typedef enum logic [1:0] {
    CLS_BORDER = 2'd0,
    CLS_PIXEL  = 2'd1,
    CLS_SYNC   = 2'd2
  } outClass_e;

  localparam logic [1:0] SEL_PEN    = 2'd0;
  localparam logic [1:0] SEL_COLOUR = 2'd1;
  localparam logic [1:0] SEL_MODE   = 2'd2;

  // strobes passed from control to datapath
  typedef struct packed {
    logic             penSelWr;
    logic             colourWr;
    logic [CPU_W-1:0] data;
  } palCmd_t;
endpackage

// File: rtl/vfp_ctrl.sv
module vfp_ctrl
  import vfp_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSync,
  input  logic              vSync,
  input  logic              dispEn,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSel,
  input  logic [CPU_W-1:0]  cpuData,
  output palCmd_t           cmd,
  output outClass_e         outClass,
  output logic              classChg,
  output logic              lineEnd,
  output logic              frameStart,
  output logic [MODE_W-1:0] activeMode
);
  logic hPrev;
  logic vPrev;
  logic modeWr;
  logic [MODE_W-1:0] modePend;
  outClass_e newClass;

  assign lineEnd    = hPrev & ~hSync;
  assign frameStart = vSync & ~vPrev;
  assign modeWr     = cpuWe && (cpuSel == SEL_MODE);

  always_comb begin
    cmd.penSelWr = cpuWe && (cpuSel == SEL_PEN);
    cmd.colourWr = cpuWe && (cpuSel == SEL_COLOUR);
    cmd.data     = cpuData;
  end

  always_comb begin
    if (hSync || vSync)  newClass = CLS_SYNC;
    else if (dispEn)     newClass = CLS_PIXEL;
    else                 newClass = CLS_BORDER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPrev      <= 1'b0;
      vPrev      <= 1'b0;
      outClass   <= CLS_BORDER;
      classChg   <= 1'b0;
      modePend   <= '0;
      activeMode <= '0;
    end else begin
      hPrev    <= hSync;
      vPrev    <= vSync;
      outClass <= newClass;
      classChg <= (newClass != outClass);
      if (modeWr)  modePend   <= cpuData[MODE_W-1:0];
      if (lineEnd) activeMode <= modePend;
    end
  end
endmodule

// File: rtl/vfp_datapath.sv
module vfp_datapath
  import vfp_pkg::*;
#(
  parameter int MA_W      = 14,
  parameter int MA_LOW_W  = 10,
  parameter int MA_HIGH_W = 2,
  parameter int RA_W      = 3,
  parameter int PEN_COUNT = 16,
  parameter int COLOUR_W  = 5,
  localparam int PEN_IDX_W = $clog2(PEN_COUNT),
  localparam int ADDR_W    = MA_HIGH_W + RA_W + MA_LOW_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  palCmd_t              cmd,
  input  logic [MA_W-1:0]      memAddr,
  input  logic [RA_W-1:0]      rowAddr,
  input  logic [PEN_IDX_W-1:0] penIdx,
  output logic [ADDR_W-1:0]    fetchAddrA,
  output logic [ADDR_W-1:0]    fetchAddrB,
  output logic [COLOUR_W-1:0]  penColour,
  output logic [COLOUR_W-1:0]  borderColour
);
  localparam int GAP_W = MA_W - MA_HIGH_W - MA_LOW_W;

  logic [PEN_IDX_W:0]   penSel;
  logic [COLOUR_W-1:0]  palette [PEN_COUNT];
  logic [ADDR_W-2:0]    addrBase;
  logic                 toBorder;
  logic                 unusedBits;

  // middle memory-address bits are not part of the RAM address
  assign unusedBits = ^{memAddr[MA_LOW_W +: GAP_W], cmd.data[CPU_W-1:COLOUR_W]};

  assign addrBase   = {memAddr[MA_W-1 -: MA_HIGH_W], rowAddr, memAddr[MA_LOW_W-1:0]};
  assign fetchAddrA = {addrBase, 1'b0};
  assign fetchAddrB = {addrBase, 1'b1};

  assign toBorder  = penSel[PEN_IDX_W];
  assign penColour = palette[penIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      penSel       <= '0;
      borderColour <= '0;
    end else begin
      if (cmd.penSelWr) penSel <= cmd.data[PEN_IDX_W:0];
      if (cmd.colourWr && toBorder) borderColour <= cmd.data[COLOUR_W-1:0];
    end
  end

  for (genvar g = 0; g < PEN_COUNT; g++) begin : gPen
    always_ff @(posedge clk) begin
      if (!rstN)
        palette[g] <= '0;
      else if (cmd.colourWr && !toBorder && (penSel[PEN_IDX_W-1:0] == PEN_IDX_W'(g)))
        palette[g] <= cmd.data[COLOUR_W-1:0];
    end
  end
endmodule

// File: rtl/video_fetch_pal.sv
module video_fetch_pal
  import vfp_pkg::*;
#(
  parameter int MA_W      = 14,
  parameter int MA_LOW_W  = 10,
  parameter int MA_HIGH_W = 2,
  parameter int RA_W      = 3,
  parameter int PEN_COUNT = 16,
  parameter int COLOUR_W  = 5,
  parameter int MODE_W    = 2,
  localparam int PEN_IDX_W = $clog2(PEN_COUNT),
  localparam int ADDR_W    = MA_HIGH_W + RA_W + MA_LOW_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MA_W-1:0]      memAddr,
  input  logic [RA_W-1:0]      rowAddr,
  input  logic                 hSync,
  input  logic                 vSync,
  input  logic                 dispEn,
  input  logic                 cpuWe,
  input  logic [1:0]           cpuSel,
  input  logic [CPU_W-1:0]     cpuData,
  input  logic [PEN_IDX_W-1:0] penIdx,
  output logic [ADDR_W-1:0]    fetchAddrA,
  output logic [ADDR_W-1:0]    fetchAddrB,
  output logic [1:0]           outClass,
  output logic                 classChg,
  output logic                 lineEnd,
  output logic                 frameStart,
  output logic [MODE_W-1:0]    activeMode,
  output logic [COLOUR_W-1:0]  penColour,
  output logic [COLOUR_W-1:0]  borderColour
);
  palCmd_t   cmd;
  outClass_e classQ;

  assign outClass = classQ;

  vfp_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hSync      (hSync),
    .vSync      (vSync),
    .dispEn     (dispEn),
    .cpuWe      (cpuWe),
    .cpuSel     (cpuSel),
    .cpuData    (cpuData),
    .cmd        (cmd),
    .outClass   (classQ),
    .classChg   (classChg),
    .lineEnd    (lineEnd),
    .frameStart (frameStart),
    .activeMode (activeMode)
  );

  vfp_datapath #(
    .MA_W(MA_W), .MA_LOW_W(MA_LOW_W), .MA_HIGH_W(MA_HIGH_W),
    .RA_W(RA_W), .PEN_COUNT(PEN_COUNT), .COLOUR_W(COLOUR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .memAddr      (memAddr),
    .rowAddr      (rowAddr),
    .penIdx       (penIdx),
    .fetchAddrA   (fetchAddrA),
    .fetchAddrB   (fetchAddrB),
    .penColour    (penColour),
    .borderColour (borderColour)
  );
endmodule

// File: rtl/vfp_checker.sv
module vfp_checker #(
  parameter int RA_W   = 3,
  parameter int ADDR_W = 16,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [RA_W-1:0]   rowAddr,
  input logic              hSync,
  input logic              vSync,
  input logic              dispEn,
  input logic [ADDR_W-1:0] fetchAddrA,
  input logic [ADDR_W-1:0] fetchAddrB,
  input logic [1:0]        outClass,
  input logic              classChg,
  input logic              lineEnd,
  input logic              frameStart,
  input logic [MODE_W-1:0] activeMode
);
  localparam int RA_LSB = ADDR_W - 2 - RA_W;

  assert_fetch_pair_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddrA[RA_LSB +: RA_W] == rowAddr) && !fetchAddrA[0] &&
    (fetchAddrB == (fetchAddrA | ADDR_W'(1))));

  assert_sync_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hSync || vSync) |=> (outClass == 2'd2));

  assert_pixel_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hSync && !vSync && dispEn) |=> (outClass == 2'd1));

  assert_border_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hSync && !vSync && !dispEn) |=> (outClass == 2'd0));

  assert_change_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    classChg == (outClass != $past(outClass)));

  assert_mode_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnd |=> $stable(activeMode));

  assert_line_end_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |-> !hSync);

  assert_frame_start_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> vSync);
endmodule

bind video_fetch_pal vfp_checker #(
  .RA_W(RA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)
) u_vfp_checker (
  .clk(clk), .rstN(rstN), .rowAddr(rowAddr), .hSync(hSync), .vSync(vSync),
  .dispEn(dispEn), .fetchAddrA(fetchAddrA), .fetchAddrB(fetchAddrB),
  .outClass(outClass), .classChg(classChg), .lineEnd(lineEnd),
  .frameStart(frameStart), .activeMode(activeMode)
);

// File: tb/video_fetch_pal_bench.sv
module video_fetch_pal_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [13:0] memAddr;
  logic [2:0]  rowAddr;
  logic        hSync, vSync, dispEn;
  logic        cpuWe;
  logic [1:0]  cpuSel;
  logic [7:0]  cpuData;
  logic [3:0]  penIdx;
  logic [15:0] fetchAddrA, fetchAddrB;
  logic [1:0]  outClass;
  logic        classChg, lineEnd, frameStart;
  logic [1:0]  activeMode;
  logic [4:0]  penColour, borderColour;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // entry fields: {hSync, vSync, dispEn, expected class[1:0], expected strobe}
  localparam logic [5:0] CLASS_TBL [10] = '{
    6'b000_00_0, 6'b001_01_1, 6'b010_10_1, 6'b011_10_0, 6'b100_10_0,
    6'b101_10_0, 6'b110_10_0, 6'b111_10_0, 6'b001_01_1, 6'b000_00_1
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  video_fetch_pal u_video_fetch_pal (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .rowAddr(rowAddr),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn), .cpuWe(cpuWe),
    .cpuSel(cpuSel), .cpuData(cpuData), .penIdx(penIdx),
    .fetchAddrA(fetchAddrA), .fetchAddrB(fetchAddrB), .outClass(outClass),
    .classChg(classChg), .lineEnd(lineEnd), .frameStart(frameStart),
    .activeMode(activeMode), .penColour(penColour), .borderColour(borderColour)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cpuWrite(input logic [1:0] sel, input logic [7:0] data);
    cpuWe = 1'b1; cpuSel = sel; cpuData = data;
    tick();
    cpuWe = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; memAddr = '0; rowAddr = '0; hSync = 0; vSync = 0; dispEn = 0;
    cpuWe = 0; cpuSel = 2'd3; cpuData = '0; penIdx = '0;
    repeat (3) tick();
    rstN = 1'b1;

    // R10 reset state
    check("R10 outClass", outClass, 0);
    check("R10 classChg", classChg, 0);
    check("R10 activeMode", activeMode, 0);
    check("R10 borderColour", borderColour, 0);
    for (int i = 0; i < 16; i++) begin
      penIdx = 4'(i); #1;
      check("R10 palette", penColour, 0);
    end

    // R2 R3 R4 classification table walk
    for (int i = 0; i < 10; i++) begin
      {hSync, vSync, dispEn} = CLASS_TBL[i][5:3];
      tick();
      check("R2/R3 class", outClass, CLASS_TBL[i][2:1]);
      check("R4 strobe", classChg, CLASS_TBL[i][0]);
    end
    tick();
    check("R4 strobe one cycle", classChg, 0);

    // R1 address formation
    memAddr = 14'h3FFF; rowAddr = 3'd0; #1;
    check("R1 addrA", fetchAddrA, 16'hC7FE);
    check("R1 addrB", fetchAddrB, 16'hC7FF);
    memAddr = 14'h0C00; rowAddr = 3'd5; #1;
    check("R1 addrA gap", fetchAddrA, 16'h2800);
    memAddr = 14'h1001; rowAddr = 3'd2; #1;
    check("R1 addrB mixed", fetchAddrB, 16'h5003);

    // R5 pending mode held until line end
    cpuWrite(2'd2, 8'h03);
    check("R5 mode pending", activeMode, 0);
    hSync = 1; tick();
    check("R5 mode held in sync", activeMode, 0);
    hSync = 0; #1;
    check("R6 lineEnd", lineEnd, 1);
    tick();
    check("R6 mode taken", activeMode, 3);
    check("R6 lineEnd cleared", lineEnd, 0);

    // R7 write and line end on the same edge
    hSync = 1; tick();
    hSync = 0;
    cpuWrite(2'd2, 8'hFE);
    check("R7 old pending taken", activeMode, 3);
    hSync = 1; tick();
    hSync = 0; tick();
    check("R7 new mode later", activeMode, 2);

    // R11 ignored writes
    cpuWe = 0; cpuSel = 2'd2; cpuData = 8'h01;
    hSync = 1; tick();
    hSync = 0; tick();
    check("R11 no-we mode", activeMode, 2);
    cpuWrite(2'd3, 8'h1F);
    hSync = 1; tick();
    hSync = 0; tick();
    check("R11 sel3 mode", activeMode, 2);

    // R8 palette writes
    cpuWrite(2'd0, 8'h05);
    cpuWrite(2'd1, 8'h15);
    penIdx = 4'd5; #1;
    check("R8 pen5", penColour, 5'h15);
    penIdx = 4'd4; #1;
    check("R8 pen4 untouched", penColour, 0);
    check("R8 border untouched", borderColour, 0);
    cpuWrite(2'd0, 8'h10);
    cpuWrite(2'd1, 8'h0A);
    check("R8 border", borderColour, 5'h0A);
    penIdx = 4'd0; #1;
    check("R8 pen0 untouched", penColour, 0);
    penIdx = 4'd5; #1;
    check("R8 pen5 kept", penColour, 5'h15);
    cpuWrite(2'd0, 8'h1F);
    cpuWrite(2'd1, 8'h1F);
    penIdx = 4'd15; #1;
    check("R8 pen15 untouched", penColour, 0);
    check("R8 border all ones", borderColour, 5'h1F);
    cpuWrite(2'd0, 8'h0F);
    cpuWrite(2'd1, 8'hE3);
    check("R8 pen15 low bits", penColour, 5'h03);
    cpuWe = 0; cpuSel = 2'd1; cpuData = 8'h11;
    tick();
    check("R11 no-we colour", penColour, 5'h03);

    // R9 frame start
    vSync = 1; #1;
    check("R9 frameStart", frameStart, 1);
    tick();
    check("R9 frameStart cleared", frameStart, 0);
    vSync = 0; tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule